// File: doc/BRIEF.md
# Segmented String Address Unit

This block produces the bus addresses and the pointer updates for block memory transfers that step through a segmented address space. Each request latches a 16-bit segment value, a 16-bit offset pointer, a direction flag and a byte/word size select. The block then issues one or two byte-lane bus cycles, each carrying a 20-bit physical address, and returns the updated offset pointer. A word at an odd offset cannot be moved in one aligned cycle. The block therefore splits it into two byte cycles and corrects the pointer afterwards with a signed step.

Every pointer adjustment comes from a small table of signed constants and goes through a dedicated step adder, so no general ALU is involved. Each constant is a sign bit plus a 3-bit magnitude. The same path also provides a correction mode, which reduces a fetch pointer by the current prefetch queue length and issues no bus cycle.

The controller is a four-state machine:
- `ST_IDLE` waits for a request.
- `ST_LEAD` issues the first (often the only) bus cycle.
- `ST_TRAIL` issues the second byte of a split word.
- `ST_FIX` performs the queue-length correction.

The transitions are:
- `ST_IDLE` goes to `ST_FIX` on a request with correction selected, and to `ST_LEAD` on any other request.
- `ST_LEAD` goes to `ST_TRAIL` for a split word and back to `ST_IDLE` otherwise.
- `ST_TRAIL` and `ST_FIX` always return to `ST_IDLE`.

Top module: `str_addr_unit`

## Requirements
- R1: After reset `busy_o`, `done_o` and `bus_valid_o` are 0 and `ofs_o` is 0x0000.
- R2: Every bus cycle drives `bus_addr_o` = (segment × 16 + offset) modulo 2^20. The offset has already wrapped modulo 2^16 before the segment base is added.
- R3: A byte transfer issues exactly one bus cycle, in the cycle after the request is accepted, with `done_o` high in that same cycle. `bus_lane_o` is 2'b01 for an even offset and 2'b10 for an odd offset (bit 0 is the even byte lane, bit 1 the odd lane). The pointer moves +1 when `dir_i`=0 and −1 when `dir_i`=1.
- R4: A word at an even offset issues one bus cycle with `bus_lane_o` = 2'b11 and `done_o` high. The pointer moves +2 (`dir_i`=0) or −2 (`dir_i`=1).
- R5: A word at an odd offset issues two consecutive bus cycles. The first is at the offset on lane 2'b10 with `done_o` low. The second is at offset+1 (mod 2^16) on lane 2'b01 with `done_o` high.
- R6: After a split word the returned pointer is offset+2 going up and offset−2 going down. Going down, this comes from the intermediate +1 followed by a −3 step.
- R7: In correction mode (`corr_i`=1) no bus cycle is issued. `done_o` is high in the cycle after acceptance, and `ofs_o` = (offset − `qlen_i`) mod 2^16.
- R8: `busy_o` is high from the cycle after acceptance through the `done_o` cycle and low in the cycle after it. A request raised while busy is ignored and does not change the operation in flight.
- R9: `ofs_o` shows the updated pointer in the `done_o` cycle and holds it while idle until the next request is accepted.
- R10: Pointer arithmetic wraps modulo 2^16: 0xFFFF stepped up by a byte gives 0x0000, and 0x0000 stepped down by a word gives 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, accepted only while idle |
| corr_i | input | 1 | 1 selects queue-length correction instead of a transfer |
| seg_i | input | 16 | Segment value |
| ofs_i | input | 16 | Offset pointer, or the fetch pointer in correction mode |
| dir_i | input | 1 | 0 steps up, 1 steps down |
| word_i | input | 1 | 1 selects a word transfer, 0 a byte transfer |
| qlen_i | input | 3 | Prefetch queue length, used in correction mode |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Final cycle of the operation |
| bus_valid_o | output | 1 | A bus cycle is issued this cycle |
| bus_addr_o | output | 20 | Physical address of the bus cycle |
| bus_lane_o | output | 2 | Byte lanes used: bit 0 even, bit 1 odd |
| ofs_o | output | 16 | Updated pointer |

## Verification
The bench aims at three kinds of corner case.

The first is the split word in both directions. A design that forgot the −3 compensation would return offset−4 or offset+0 going down. A design that skipped the split would drive one cycle on lane 2'b11 at an odd address.

The second is wrapping at both boundaries. At offset 0xFFFF and at segment 0xFFFF, a design that added before truncating would carry into the segment base or produce a 21st address bit.

The third covers correction mode and requests raised mid-operation. Correction across zero must wrap to 0xFFFD. A controller that accepted a request while busy would corrupt the second cycle of a split word or the returned pointer.

// File: rtl/sau_pkg.sv
package sau_pkg;

    // Width of the magnitude field of a step constant.
    localparam int MAG_W = 3;

    // Controller states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_FIX   = 2'd3
    } sau_state_e;

    // Selector into the signed constant table.
    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_UP1   = 3'd1,
        K_UP2   = 3'd2,
        K_DN1   = 3'd3,
        K_DN2   = 3'd4,
        K_DN3   = 3'd5,
        K_QUEUE = 3'd6
    } step_sel_e;

    // Constant: sign bit plus magnitude.
    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } step_code_t;

endpackage

// File: rtl/sau_step_rom.sv
module sau_step_rom
    import sau_pkg::*;
#(
    parameter int QLEN_W = 3
) (
    input  step_sel_e           sel_i,
    input  logic [QLEN_W-1:0]   qlen_i,
    output step_code_t          code_o
);

    logic [MAG_W-1:0] qmag;

    // Fit the queue length into the magnitude field.
    generate
        if (QLEN_W >= MAG_W) begin : g_trunc
            assign qmag = qlen_i[MAG_W-1:0];
        end else begin : g_pad
            assign qmag = {{(MAG_W-QLEN_W){1'b0}}, qlen_i};
        end
    endgenerate

    always_comb begin
        code_o = '{neg: 1'b0, mag: '0};
        unique case (sel_i)
            K_NONE:  code_o = '{neg: 1'b0, mag: MAG_W'(0)};
            K_UP1:   code_o = '{neg: 1'b0, mag: MAG_W'(1)};
            K_UP2:   code_o = '{neg: 1'b0, mag: MAG_W'(2)};
            K_DN1:   code_o = '{neg: 1'b1, mag: MAG_W'(1)};
            K_DN2:   code_o = '{neg: 1'b1, mag: MAG_W'(2)};
            K_DN3:   code_o = '{neg: 1'b1, mag: MAG_W'(3)};
            K_QUEUE: code_o = '{neg: 1'b1, mag: qmag};
            default: code_o = '{neg: 1'b0, mag: MAG_W'(0)};
        endcase
    end

endmodule

// File: rtl/sau_step_add.sv
module sau_step_add
    import sau_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic [OFS_W-1:0] ptr_i,
    input  step_code_t       code_i,
    output logic [OFS_W-1:0] ptr_o
);

    logic [OFS_W-1:0] mag_ext;

    assign mag_ext = {{(OFS_W-MAG_W){1'b0}}, code_i.mag};

    // Modulo 2^OFS_W: the result simply drops the carry or borrow.
    always_comb begin
        if (code_i.neg) begin
            ptr_o = ptr_i - mag_ext;
        end else begin
            ptr_o = ptr_i + mag_ext;
        end
    end

endmodule

// File: rtl/sau_phys_add.sv
module sau_phys_add #(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ofs_ext;

    assign base    = {seg_i, {SHIFT{1'b0}}};
    assign ofs_ext = {{(ADDR_W-OFS_W){1'b0}}, ofs_i};
    assign addr_o  = base + ofs_ext;

endmodule

// File: rtl/sau_ctrl.sv
module sau_ctrl
    import sau_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_i,
    input  logic      corr_i,
    input  logic      word_q,
    input  logic      dir_q,
    input  logic      odd_q,
    output logic      take_o,
    output logic      busy_o,
    output logic      done_o,
    output logic      bus_valid_o,
    output logic [1:0] lane_o,
    output step_sel_e sel_o
);

    sau_state_e state_q, state_d;
    logic       split;

    assign split = word_q & odd_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    state_d = corr_i ? ST_FIX : ST_LEAD;
                end
            end
            ST_LEAD:  state_d = split ? ST_TRAIL : ST_IDLE;
            ST_TRAIL: state_d = ST_IDLE;
            ST_FIX:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs per state.
    always_comb begin
        take_o      = 1'b0;
        busy_o      = 1'b0;
        done_o      = 1'b0;
        bus_valid_o = 1'b0;
        lane_o      = 2'b00;
        sel_o       = K_NONE;
        unique case (state_q)
            ST_IDLE: begin
                take_o = req_i;
            end
            ST_LEAD: begin
                busy_o      = 1'b1;
                bus_valid_o = 1'b1;
                if (split) begin
                    lane_o = 2'b10;
                    sel_o  = K_UP1;
                end else begin
                    done_o = 1'b1;
                    if (word_q) begin
                        lane_o = 2'b11;
                        sel_o  = dir_q ? K_DN2 : K_UP2;
                    end else begin
                        lane_o = odd_q ? 2'b10 : 2'b01;
                        sel_o  = dir_q ? K_DN1 : K_UP1;
                    end
                end
            end
            ST_TRAIL: begin
                busy_o      = 1'b1;
                bus_valid_o = 1'b1;
                done_o      = 1'b1;
                lane_o      = 2'b01;
                sel_o       = dir_q ? K_DN3 : K_UP1;
            end
            ST_FIX: begin
                busy_o = 1'b1;
                done_o = 1'b1;
                sel_o  = K_QUEUE;
            end
            default: begin
                take_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/str_addr_unit.sv
module str_addr_unit
    import sau_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    parameter int QLEN_W = 3,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              corr_i,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              dir_i,
    input  logic              word_i,
    input  logic [QLEN_W-1:0] qlen_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              bus_valid_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [1:0]        bus_lane_o,
    output logic [OFS_W-1:0]  ofs_o
);

    logic [SEG_W-1:0]  seg_q;
    logic [OFS_W-1:0]  ptr_q;
    logic [QLEN_W-1:0] qlen_q;
    logic              dir_q;
    logic              word_q;
    logic              corr_q;

    logic              take;
    logic              busy;
    step_sel_e         sel;
    step_code_t        code;
    logic [OFS_W-1:0]  ptr_next;
    logic [ADDR_W-1:0] phys;

    sau_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .corr_i      (corr_i),
        .word_q      (word_q),
        .dir_q       (dir_q),
        .odd_q       (ptr_q[0]),
        .take_o      (take),
        .busy_o      (busy),
        .done_o      (done_o),
        .bus_valid_o (bus_valid_o),
        .lane_o      (bus_lane_o),
        .sel_o       (sel)
    );

    sau_step_rom #(.QLEN_W(QLEN_W)) i_rom (
        .sel_i  (sel),
        .qlen_i (qlen_q),
        .code_o (code)
    );

    sau_step_add #(.OFS_W(OFS_W)) i_step (
        .ptr_i  (ptr_q),
        .code_i (code),
        .ptr_o  (ptr_next)
    );

    sau_phys_add #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) i_phys (
        .seg_i  (seg_q),
        .ofs_i  (ptr_q),
        .addr_o (phys)
    );

    // Operand registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q  <= '0;
            ptr_q  <= '0;
            qlen_q <= '0;
            dir_q  <= 1'b0;
            word_q <= 1'b0;
            corr_q <= 1'b0;
        end else if (take) begin
            seg_q  <= seg_i;
            ptr_q  <= ofs_i;
            qlen_q <= qlen_i;
            dir_q  <= dir_i;
            word_q <= word_i;
            corr_q <= corr_i;
        end else if (busy) begin
            ptr_q  <= ptr_next;
        end
    end

    assign busy_o     = busy;
    assign bus_addr_o = bus_valid_o ? phys : '0;
    assign ofs_o      = ptr_next;

endmodule

// File: rtl/sau_checker.sv
module sau_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       bus_valid_o,
    input logic [1:0] bus_lane_o,
    input logic [15:0] ofs_o,
    input logic       corr_q
);

    assert_valid_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |-> busy_o);

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i) |=> busy_o);

    assert_done_leaves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    assert_lead_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && !done_o) |-> (bus_lane_o == 2'b10));

    assert_split_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && !done_o) |=> (bus_valid_o && done_o && bus_lane_o == 2'b01));

    assert_lane_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |-> (bus_lane_o != 2'b00));

    assert_corr_nobus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && corr_q) |-> (!bus_valid_o && done_o));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !req_i) |=> $stable(ofs_o));

endmodule

bind str_addr_unit sau_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .bus_valid_o (bus_valid_o),
    .bus_lane_o  (bus_lane_o),
    .ofs_o       (ofs_o),
    .corr_q      (corr_q)
);

// File: tb/test_str_addr_unit.sv
module test_str_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        corr_i = 1'b0;
    logic [15:0] seg_i = '0;
    logic [15:0] ofs_i = '0;
    logic        dir_i = 1'b0;
    logic        word_i = 1'b0;
    logic [2:0]  qlen_i = '0;
    logic        busy_o, done_o, bus_valid_o;
    logic [19:0] bus_addr_o;
    logic [1:0]  bus_lane_o;
    logic [15:0] ofs_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    str_addr_unit i_str_addr_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .corr_i(corr_i),
        .seg_i(seg_i), .ofs_i(ofs_i), .dir_i(dir_i), .word_i(word_i),
        .qlen_i(qlen_i), .busy_o(busy_o), .done_o(done_o),
        .bus_valid_o(bus_valid_o), .bus_addr_o(bus_addr_o),
        .bus_lane_o(bus_lane_o), .ofs_o(ofs_o)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
        logic [19:0] b;
        b = {s, 4'h0};
        return b + {4'h0, o};
    endfunction

    // One operation, checked cycle by cycle. poke raises a foreign request while busy.
    task automatic run_op(string tag, bit corr, logic [15:0] seg, logic [15:0] ofs,
                          bit dir, bit word, logic [2:0] ql, bit poke);
        logic [15:0] exp_ptr;
        logic [15:0] ofs2;
        bit          split;
        split = !corr && word && ofs[0];
        ofs2  = ofs + 16'd1;
        if (corr)      exp_ptr = ofs - {13'd0, ql};
        else if (word) exp_ptr = dir ? ofs - 16'd2 : ofs + 16'd2;
        else           exp_ptr = dir ? ofs - 16'd1 : ofs + 16'd1;

        @(negedge clk);
        req_i = 1'b1; corr_i = corr; seg_i = seg; ofs_i = ofs;
        dir_i = dir; word_i = word; qlen_i = ql;
        @(negedge clk);
        req_i = 1'b0;
        // First cycle after acceptance.
        chk(tag, "busy c1 (R8)", {31'd0, busy_o}, 32'd1);
        if (corr) begin
            chk(tag, "no bus in correction (R7)", {31'd0, bus_valid_o}, 32'd0);
            chk(tag, "done c1 (R7)", {31'd0, done_o}, 32'd1);
            chk(tag, "corrected ptr (R7)", {16'd0, ofs_o}, {16'd0, exp_ptr});
        end else begin
            chk(tag, "bus valid c1", {31'd0, bus_valid_o}, 32'd1);
            chk(tag, "addr c1 (R2)", {12'd0, bus_addr_o}, {12'd0, phys(seg, ofs)});
            if (split) begin
                chk(tag, "lane lead (R5)", {30'd0, bus_lane_o}, 32'd2);
                chk(tag, "no done lead (R5)", {31'd0, done_o}, 32'd0);
            end else begin
                chk(tag, "lane single (R3/R4)", {30'd0, bus_lane_o},
                    word ? 32'd3 : (ofs[0] ? 32'd2 : 32'd1));
                chk(tag, "done single (R3/R4)", {31'd0, done_o}, 32'd1);
                chk(tag, "ptr single (R3/R4)", {16'd0, ofs_o}, {16'd0, exp_ptr});
            end
        end
        if (poke) begin
            req_i = 1'b1; corr_i = 1'b1; seg_i = ~seg; ofs_i = ~ofs;
            dir_i = ~dir; word_i = ~word; qlen_i = 3'd7;
        end
        if (split) begin
            @(negedge clk);
            req_i = 1'b0;
            chk(tag, "busy c2 (R8)", {31'd0, busy_o}, 32'd1);
            chk(tag, "bus valid c2 (R5)", {31'd0, bus_valid_o}, 32'd1);
            chk(tag, "addr c2 (R5)", {12'd0, bus_addr_o}, {12'd0, phys(seg, ofs2)});
            chk(tag, "lane trail (R5)", {30'd0, bus_lane_o}, 32'd1);
            chk(tag, "done c2 (R5)", {31'd0, done_o}, 32'd1);
            chk(tag, "ptr split (R6)", {16'd0, ofs_o}, {16'd0, exp_ptr});
        end
        @(negedge clk);
        req_i = 1'b0;
        chk(tag, "idle after done (R8)", {31'd0, busy_o}, 32'd0);
        chk(tag, "no bus idle (R8)", {31'd0, bus_valid_o}, 32'd0);
        @(negedge clk);
        chk(tag, "ptr held idle (R9)", {16'd0, ofs_o}, {16'd0, exp_ptr});
    endtask

    task automatic t_reset();
        chk("R1", "busy", {31'd0, busy_o}, 32'd0);
        chk("R1", "done", {31'd0, done_o}, 32'd0);
        chk("R1", "bus_valid", {31'd0, bus_valid_o}, 32'd0);
        chk("R1", "ofs", {16'd0, ofs_o}, 32'd0);
    endtask

    task automatic t_byte();    // R3
        run_op("R3", 0, 16'h1000, 16'h0040, 0, 0, 3'd0, 0);
        run_op("R3", 0, 16'h1000, 16'h0041, 1, 0, 3'd0, 0);
        run_op("R3", 0, 16'h2345, 16'h8001, 0, 0, 3'd0, 0);
    endtask

    task automatic t_word_even(); // R4
        run_op("R4", 0, 16'h0ABC, 16'h0100, 0, 1, 3'd0, 0);
        run_op("R4", 0, 16'h0ABC, 16'h0100, 1, 1, 3'd0, 0);
    endtask

    task automatic t_word_odd();  // R5 R6
        run_op("R5", 0, 16'h3000, 16'h0201, 0, 1, 3'd0, 0);
        run_op("R6", 0, 16'h3000, 16'h0201, 1, 1, 3'd0, 0);
    endtask

    task automatic t_phys();      // R2
        run_op("R2", 0, 16'hFFFF, 16'h0010, 0, 0, 3'd0, 0);
        run_op("R2", 0, 16'hF000, 16'hFFFE, 1, 1, 3'd0, 0);
    endtask

    task automatic t_wrap();      // R10
        run_op("R10", 0, 16'h0100, 16'hFFFF, 0, 0, 3'd0, 0);
        run_op("R10", 0, 16'h0100, 16'h0000, 1, 1, 3'd0, 0);
        run_op("R10", 0, 16'h0100, 16'hFFFF, 0, 1, 3'd0, 0);
        run_op("R10", 0, 16'h0100, 16'h0001, 1, 1, 3'd0, 0);
    endtask

    task automatic t_corr();      // R7
        run_op("R7", 1, 16'h0000, 16'h1234, 0, 0, 3'd5, 0);
        run_op("R7", 1, 16'h0000, 16'h0003, 0, 0, 3'd6, 0);
        run_op("R7", 1, 16'h0000, 16'h7777, 0, 0, 3'd0, 0);
    endtask

    task automatic t_busy_req();  // R8
        run_op("R8", 0, 16'h4000, 16'h0033, 1, 1, 3'd0, 1);
        run_op("R8", 0, 16'h4000, 16'h0032, 0, 0, 3'd0, 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte();
        t_word_even();
        t_word_odd();
        t_phys();
        t_wrap();
        t_corr();
        t_busy_req();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule